// File: doc/BRIEF.md
# Radar Pulse Event History Buffer

This block keeps a short history of radar pulse events so that a downstream pattern analyser can look back over them. Each accepted event carries an engine number, a pulse timestamp and a pulse width. The block adds the local time at which the event arrived and stores the result in one of two circular buffers. Events from the alternate engine (code 2) go to the second buffer. Every other engine code goes to the first buffer. A write is never refused. When a buffer is full, its oldest entry is overwritten. Entries also leave a buffer once their arrival time is older than an age window.

Two filters act on arrivals. First, an alternate-engine event that lands very soon after a wide entry already stored in the second buffer is treated as an echo and dropped. Second, an event whose timestamp is lower than that of the previous event shows that the timestamp source has restarted. In that case both buffers are emptied, and the event is then stored into the emptied buffers.

A consumer reads a buffer by pulsing a start request with a buffer select. It then receives that buffer's entries as a valid/ready stream, newest first and oldest last. The push port uses valid/ready, but its ready output is held high at all times, so a producer never sees back-pressure. The read stream advances only on a cycle where valid and ready are both high. The stream holds its current entry for as long as ready is low.

Top module: `evt_ring_top`

## Requirements
- R1: An accepted event with engine code 2 is stored only in buffer 1 (`rd_sel`=1). An accepted event with any other engine code is stored only in buffer 0.
- R2: Each buffer holds at most DEPTH-1 entries. A write into a full buffer succeeds and discards that buffer's oldest entry.
- R3: An engine-2 event is dropped when all of the following hold: buffer 1 is not empty, the event timestamp minus the newest stored timestamp in buffer 1 (modulo 2^32) is below DUP_MARGIN, and that newest entry's width is at least DUP_WIDTH. In every other case the event is stored.
- R4: Each stored entry records the value of `now_i` on the clock edge at which the event was accepted.
- R5: While a buffer is not empty and `now_i` minus the oldest entry's capture time (modulo 2^32) is at least AGE_WIN, that oldest entry is retired, one entry per cycle. Retiring stops at the first entry that is younger than the window.
- R6: After reset both buffers are empty, and a read returns no entries.
- R7: An event whose timestamp is lower than the timestamp of the previous accepted event empties both buffers. The event is then stored as the only entry of its own buffer.
- R8: After a start request, the read stream delivers every entry of the selected buffer from newest to oldest, one per valid/ready handshake. Valid then stays low.
- R9: `evt_ready` is high in every cycle, so every `evt_valid` cycle is an accepted event.
- R10: A buffer is empty exactly when its head and tail indices are equal. A write that does not clear the buffers always leaves the buffer non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | 32 | Free-running local time |
| evt_valid | input | 1 | Event push valid |
| evt_ready | output | 1 | Event push ready (always high) |
| evt_engine | input | 2 | Engine code of the event |
| evt_ts | input | 32 | Pulse timestamp |
| evt_width | input | 12 | Pulse width |
| rd_start | input | 1 | Start a read walk of the selected buffer |
| rd_sel | input | 1 | Buffer to read: 0 or 1 |
| rd_valid | output | 1 | Read stream entry valid |
| rd_ready | input | 1 | Consumer accepts the current entry |
| rd_ts | output | 32 | Timestamp of the current entry |
| rd_width | output | 12 | Width of the current entry |
| rd_capt | output | 32 | Capture time of the current entry |

## Verification
An event accepted at one rising edge is written into its buffer at that same edge. A read started at any later edge therefore sees it. A start request latched at edge N presents the newest entry during the cycle after edge N. Each following handshake edge moves the stream to the next older entry. The bench drives inputs shortly after a rising edge and samples `rd_valid` and the entry fields at the falling edge. At each such sample, its scoreboard pops one expected entry whenever valid and ready are both high. Age retirement removes one entry per cycle. After changing `now_i`, the bench therefore idles for DEPTH+4 cycles before it applies the same retirement to its model and reads the buffers.

// File: rtl/evt_ring_pkg.sv
package evt_ring_pkg;
  localparam int unsigned TS_W  = 32;
  localparam int unsigned WID_W = 12;
  localparam int unsigned TM_W  = 32;
  localparam int unsigned ENG_W = 2;

  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [WID_W-1:0] width;
    logic [TM_W-1:0]  capt;
  } evt_entry_t;
endpackage

// File: rtl/evt_ring.sv
// One circular event buffer: write with overwrite-on-full, age retirement,
// combinational read port. DEPTH must be a power of two.
module evt_ring
  import evt_ring_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned AGE_WIN = 1000,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  evt_entry_t      wr_entry,
  input  logic [TM_W-1:0] now,
  input  logic [AW-1:0]   rd_idx,
  output evt_entry_t      rd_entry,
  output evt_entry_t      newest,
  output logic            empty,
  output logic [AW-1:0]   head_o,
  output logic [AW-1:0]   tail_o
);
  evt_entry_t      mem_q [DEPTH];
  logic [AW-1:0]   head_q, tail_q, tail_nx, wr_ptr;
  logic [TM_W-1:0] age_d;
  logic            full, aged;

  assign tail_nx = tail_q + AW'(1);
  assign empty   = (head_q == tail_q);
  assign full    = (tail_nx == head_q);
  assign age_d   = now - mem_q[head_q].capt;
  assign aged    = !empty && (age_d >= TM_W'(AGE_WIN));
  assign wr_ptr  = clr ? '0 : tail_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (clr) begin
      head_q <= '0;
      tail_q <= wr_en ? AW'(1) : '0;
    end else begin
      if (wr_en) tail_q <= tail_nx;
      if ((wr_en && full) || aged) head_q <= head_q + AW'(1);
    end
  end

  assign rd_entry = mem_q[rd_idx];
  assign newest   = mem_q[tail_q - AW'(1)];
  assign head_o   = head_q;
  assign tail_o   = tail_q;
endmodule

// File: rtl/evt_ingress.sv
// Arrival filters: buffer routing, echo drop, timestamp regression clear.
module evt_ingress
  import evt_ring_pkg::*;
#(
  parameter int unsigned ALT_ENGINE = 2,
  parameter int unsigned DUP_MARGIN = 64,
  parameter int unsigned DUP_WIDTH  = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [ENG_W-1:0] engine,
  input  logic [TS_W-1:0]  ts,
  input  logic             alt_empty,
  input  evt_entry_t       alt_newest,
  output logic [1:0]       wr,
  output logic             clr
);
  logic [TS_W-1:0] last_ts_q, gap;
  logic            is_alt, echo;

  assign is_alt = (engine == ENG_W'(ALT_ENGINE));
  assign gap    = ts - alt_newest.ts;
  assign clr    = valid && (ts < last_ts_q);
  assign echo   = is_alt && !clr && !alt_empty && (gap < TS_W'(DUP_MARGIN))
                  && (alt_newest.width >= WID_W'(DUP_WIDTH));
  assign wr[0]  = valid && !is_alt;
  assign wr[1]  = valid && is_alt && !echo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_ts_q <= '0;
    else if (valid) last_ts_q <= ts;
  end
endmodule

// File: rtl/evt_reader.sv
// Backward read walker: tail-1 down to head, valid/ready stream.
module evt_reader #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sel,
  input  logic               clr,
  input  logic               rd_ready,
  input  logic [1:0][AW-1:0] head_v,
  input  logic [1:0][AW-1:0] tail_v,
  output logic [AW-1:0]      idx,
  output logic               sel_q,
  output logic               rd_valid
);
  logic          active_q;
  logic [AW-1:0] idx_q, stop_idx;

  assign stop_idx = head_v[sel_q] - AW'(1);
  assign rd_valid = active_q && (idx_q != stop_idx);
  assign idx      = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      sel_q    <= 1'b0;
    end else if (clr) begin
      active_q <= 1'b0;
    end else if (start) begin
      sel_q    <= sel;
      idx_q    <= tail_v[sel] - AW'(1);
      active_q <= 1'b1;
    end else if (!rd_valid) begin
      active_q <= 1'b0;
    end else if (rd_ready) begin
      idx_q <= idx_q - AW'(1);
    end
  end
endmodule

// File: rtl/evt_ring_top.sv
module evt_ring_top
  import evt_ring_pkg::*;
#(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned AGE_WIN    = 1000,
  parameter int unsigned DUP_MARGIN = 64,
  parameter int unsigned DUP_WIDTH  = 200,
  parameter int unsigned ALT_ENGINE = 2,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TM_W-1:0]  now_i,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [ENG_W-1:0] evt_engine,
  input  logic [TS_W-1:0]  evt_ts,
  input  logic [WID_W-1:0] evt_width,
  input  logic             rd_start,
  input  logic             rd_sel,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [TS_W-1:0]  rd_ts,
  output logic [WID_W-1:0] rd_width,
  output logic [TM_W-1:0]  rd_capt
);
  logic [1:0]         wr;
  logic               clr, sel_q;
  logic [1:0]         empty_v;
  logic [1:0][AW-1:0] head_v, tail_v;
  logic [AW-1:0]      rd_idx;
  evt_entry_t         wr_entry;
  evt_entry_t         newest_v [2];
  evt_entry_t         rd_e     [2];
  evt_entry_t         cur;

  assign evt_ready = 1'b1;
  assign wr_entry  = '{ts: evt_ts, width: evt_width, capt: now_i};

  evt_ingress #(
    .ALT_ENGINE(ALT_ENGINE), .DUP_MARGIN(DUP_MARGIN), .DUP_WIDTH(DUP_WIDTH)
  ) u_ingress (
    .clk(clk), .rst_n(rst_n), .valid(evt_valid), .engine(evt_engine),
    .ts(evt_ts), .alt_empty(empty_v[1]), .alt_newest(newest_v[1]),
    .wr(wr), .clr(clr)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ring
    evt_ring #(.DEPTH(DEPTH), .AGE_WIN(AGE_WIN)) u_ring (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr[g]),
      .wr_entry(wr_entry), .now(now_i), .rd_idx(rd_idx),
      .rd_entry(rd_e[g]), .newest(newest_v[g]), .empty(empty_v[g]),
      .head_o(head_v[g]), .tail_o(tail_v[g])
    );
  end

  evt_reader #(.DEPTH(DEPTH)) u_reader (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .sel(rd_sel), .clr(clr),
    .rd_ready(rd_ready), .head_v(head_v), .tail_v(tail_v),
    .idx(rd_idx), .sel_q(sel_q), .rd_valid(rd_valid)
  );

  assign cur      = sel_q ? rd_e[1] : rd_e[0];
  assign rd_ts    = cur.ts;
  assign rd_width = cur.width;
  assign rd_capt  = cur.capt;
endmodule

// File: rtl/evt_ring_chk.sv
module evt_ring_chk
  import evt_ring_pkg::*;
#(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned DUP_MARGIN = 64,
  parameter int unsigned DUP_WIDTH  = 200,
  parameter int unsigned ALT_ENGINE = 2,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt_valid,
  input logic [ENG_W-1:0]   evt_engine,
  input logic [TS_W-1:0]    evt_ts,
  input logic [1:0]         wr,
  input logic               clr,
  input logic [1:0][AW-1:0] head_v,
  input logic [1:0][AW-1:0] tail_v,
  input evt_entry_t         alt_newest,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic               rd_start,
  input logic [AW-1:0]      rd_idx
);
  logic [AW-1:0]   t0_nx, h0_nx;
  logic [TS_W-1:0] alt_gap;
  assign t0_nx   = tail_v[0] + AW'(1);
  assign h0_nx   = head_v[0] + AW'(1);
  assign alt_gap = evt_ts - alt_newest.ts;

  // R1
  route_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && (evt_engine != ENG_W'(ALT_ENGINE)) |-> wr[0] && !wr[1]);

  // R3
  echo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && (evt_engine == ENG_W'(ALT_ENGINE)) && !clr &&
    (tail_v[1] != head_v[1]) && (alt_gap < TS_W'(DUP_MARGIN)) &&
    (alt_newest.width >= WID_W'(DUP_WIDTH)) |-> !wr[1]);

  // R2
  overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr[0] && !clr && (t0_nx == head_v[0]) |=> head_v[0] == $past(h0_nx));

  // R7
  regress_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (head_v[0] == '0) && (head_v[1] == '0) &&
            (tail_v[0] <= AW'(1)) && (tail_v[1] <= AW'(1)));

  // R10
  nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr[0] && !clr |=> tail_v[0] != head_v[0]);

  // R8
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !rd_start && !clr |=> rd_idx == $past(rd_idx) - AW'(1));
endmodule

bind evt_ring_top evt_ring_chk #(
  .DEPTH(DEPTH), .DUP_MARGIN(DUP_MARGIN), .DUP_WIDTH(DUP_WIDTH), .ALT_ENGINE(ALT_ENGINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_engine(evt_engine),
  .evt_ts(evt_ts), .wr(wr), .clr(clr), .head_v(head_v), .tail_v(tail_v),
  .alt_newest(newest_v[1]), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_start(rd_start), .rd_idx(rd_idx)
);

// File: tb/evt_ring_top_bench.sv
module evt_ring_top_bench;
  localparam int DEPTH = 8, WIN = 1000, MARGIN = 64, WIDE = 200;

  typedef struct {
    logic [31:0] ts;
    logic [11:0] w;
    logic [31:0] c;
  } ment_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] now_i = '0;
  logic        evt_valid = 1'b0, evt_ready;
  logic [1:0]  evt_engine = '0;
  logic [31:0] evt_ts = '0;
  logic [11:0] evt_width = '0;
  logic        rd_start = 1'b0, rd_sel = 1'b0, rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_ts, rd_capt;
  logic [11:0] rd_width;

  int          vectors = 0, fails = 0;
  string       cur_req = "R8";
  logic [31:0] last_ts = '0;
  ment_t       mq0[$], mq1[$], exp_q[$];

  always #5 clk = ~clk;

  evt_ring_top #(.DEPTH(DEPTH), .AGE_WIN(WIN), .DUP_MARGIN(MARGIN), .DUP_WIDTH(WIDE)) u_evt_ring_top (
    .clk(clk), .rst_n(rst_n), .now_i(now_i), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_engine(evt_engine), .evt_ts(evt_ts), .evt_width(evt_width),
    .rd_start(rd_start), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_ts(rd_ts), .rd_width(rd_width), .rd_capt(rd_capt)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // monitor: scoreboard pop on each handshake
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: extra entry ts=%0d, expected none", cur_req, rd_ts);
      end else begin
        ment_t e;
        e = exp_q.pop_front();
        if (rd_ts !== e.ts || rd_width !== e.w || rd_capt !== e.c) begin
          fails++;
          $display("FAIL %s: got ts=%0d w=%0d c=%0d, expected ts=%0d w=%0d c=%0d",
                   cur_req, rd_ts, rd_width, rd_capt, e.ts, e.w, e.c);
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver: one accepted event, model updated from the requirements
  task automatic push(int eng, logic [31:0] ts, logic [11:0] w);
    ment_t m;
    @(posedge clk); #1;
    evt_valid = 1'b1; evt_engine = 2'(eng); evt_ts = ts; evt_width = w;
    check(evt_ready === 1'b1, "R9", "evt_ready", int'(evt_ready), 1);
    m.ts = ts; m.w = w; m.c = now_i;
    if (ts < last_ts) begin mq0.delete(); mq1.delete(); end   // R7
    last_ts = ts;
    if (eng == 2) begin                                        // R1, R3
      if (!(mq1.size() > 0 && (ts - mq1[$].ts) < MARGIN && mq1[$].w >= WIDE)) begin
        mq1.push_back(m);
        if (mq1.size() > DEPTH - 1) void'(mq1.pop_front());    // R2
      end
    end else begin
      mq0.push_back(m);
      if (mq0.size() > DEPTH - 1) void'(mq0.pop_front());
    end
    @(posedge clk); #1;
    evt_valid = 1'b0;
  endtask

  task automatic set_now_and_age(logic [31:0] t);   // R5
    @(posedge clk); #1;
    now_i = t;
    repeat (DEPTH + 4) @(posedge clk);
    #1;
    while (mq0.size() > 0 && (now_i - mq0[0].c) >= WIN) void'(mq0.pop_front());
    while (mq1.size() > 0 && (now_i - mq1[0].c) >= WIN) void'(mq1.pop_front());
  endtask

  task automatic read_chk(int sel, string req);
    int n;
    cur_req = req;
    exp_q.delete();
    if (sel == 1) for (int i = mq1.size() - 1; i >= 0; i--) exp_q.push_back(mq1[i]);
    else          for (int i = mq0.size() - 1; i >= 0; i--) exp_q.push_back(mq0[i]);
    n = exp_q.size();
    @(posedge clk); #1;
    rd_start = 1'b1; rd_sel = sel[0]; rd_ready = 1'b1;
    @(posedge clk); #1;
    rd_start = 1'b0;
    for (int k = 0; k < 2 * DEPTH + 4; k++) begin
      @(negedge clk);
      if (!rd_valid) break;
    end
    check(exp_q.size() == 0, req, "entries left unread of", exp_q.size(), n);
    @(posedge clk); #1;
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R6: both buffers empty after reset
    read_chk(0, "R6");
    read_chk(1, "R6");
    check(evt_ready === 1'b1, "R9", "evt_ready idle", int'(evt_ready), 1);

    // R1 routing and R8 order
    push(0, 10, 50); push(2, 20, 50); push(1, 30, 60); push(3, 40, 70);
    read_chk(0, "R1");
    read_chk(1, "R1");

    // R4 capture time
    @(posedge clk); #1 now_i = 300;
    push(0, 50, 80);
    read_chk(0, "R4");

    // R3 echo filter
    push(2, 100, 250);   // kept: newest width 50
    push(2, 110, 10);    // dropped: gap 10, newest width 250
    push(2, 300, 10);    // kept: gap 200
    push(2, 310, 10);    // kept: newest width 10
    push(0, 320, 5);     // engine 0 unaffected
    read_chk(1, "R3");

    // R2 / R10 overwrite on full
    for (int i = 0; i < 10; i++) push(0, 32'(400 + 10 * i), 12'(i + 1));
    read_chk(0, "R2");
    read_chk(0, "R10");

    // R7 timestamp regression
    push(0, 5, 33);
    read_chk(0, "R7");
    read_chk(1, "R7");

    // R5 aging
    set_now_and_age(2000);
    read_chk(0, "R5");
    push(0, 20, 1); push(0, 30, 2);
    @(posedge clk); #1 now_i = 2600;
    push(2, 40, 10); push(0, 50, 3);
    set_now_and_age(3100);
    read_chk(0, "R5");
    read_chk(1, "R5");
    read_chk(1, "R8");

    summary();
    $finish;
  end
endmodule